// File: doc/BRIEF.md
# Tiled Image Copy Engine with Box Downscale

This engine moves a rectangular image of 32-bit RGBA pixels from a source buffer to a destination buffer. On the way it can change the memory layout between plain row-major order and a tiled order, in which pixels are grouped in 8x8 blocks using a Morton (Z-order) interleave. It can also shrink the picture by two in width alone, or by two in both directions, with a box filter. Optionally, the rows are written in reverse order.

A transfer is programmed through configuration inputs and started with a one-cycle `start` pulse, which captures the configuration. The engine first checks the settings. If they are legal, it visits every output pixel in raster order. For each pixel it issues one, two or four word reads and then one word write. A memory that returns read data one cycle after the request is assumed. The end of every run is marked by a one-cycle `done` pulse. An illegal setup raises `rejected` alongside `done` and performs no memory access.

Top module: `disp_xfer_engine`

## Requirements
- R1: A run is rejected (`done` and `rejected` high together for one cycle, two clock edges after the start edge, with no write) if either base address has its two low bits nonzero or is not below MEM_BYTES, or if any of source width, source height, destination width or destination height is zero.
- R2: The scale code `scale_mode` is decoded as 0 = no scaling, 1 = halve width (2 samples), 2 = halve width and height (4 samples). Code 3 is rejected as in R1.
- R3: A nonzero scale code combined with `src_linear` = 1 is rejected as in R1.
- R4: The effective output width is `dst_w` shifted right by one whenever the scale code is nonzero. The effective output height is `dst_h` shifted right by one only for code 2. Exactly effective width × effective height words are written.
- R5: The row-major byte offset of pixel (x, y) in an image of row length w pixels is (x + y·w)·4.
- R6: The tiled byte offset of (x, y) is 4·(m + 64·⌊x/8⌋) + (y with bits 2:0 cleared)·w·4. Here m = {y2,x2,y1,x1,y0,x0}, with x0 as the least significant bit.
- R7: The source is row-major when `src_linear` = 1 and tiled otherwise. The destination is tiled when `src_linear` XOR `keep_layout` is 1 and row-major otherwise. The source row length is `src_w`; the destination row length is the effective width.
- R8: The source coordinate of output pixel (x, y) is (x << hshift, y << vshift). With `flip_y` = 1, that pixel is stored at destination row (effective height − 1 − y).
- R9: Each output word is the per-byte-lane mean of the 1, 2 or 4 consecutive words starting at the source offset. Each of the four byte lanes is summed on its own and divided with truncation.
- R10: `busy` is high from the edge after an accepted `start` until `done`. While `busy` is high, `start` is ignored. `done` lasts one cycle.
- R11: Each output pixel takes one read cycle per sample, one cycle for the last read data to arrive, and one write cycle. An accepted legal run therefore lasts 2 + P·(samples + 2) edges from the start edge to `done`. A read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; configuration captured on this edge |
| src_base | input | ADDR_W | Source buffer byte address |
| dst_base | input | ADDR_W | Destination buffer byte address |
| src_w | input | DIM_W | Source width in pixels (row length) |
| src_h | input | DIM_W | Source height in pixels |
| dst_w | input | DIM_W | Programmed destination width before scaling |
| dst_h | input | DIM_W | Programmed destination height before scaling |
| src_linear | input | 1 | Source is row-major (else tiled) |
| keep_layout | input | 1 | Selects destination layout with `src_linear` (R7) |
| scale_mode | input | 2 | Scale code (R2) |
| flip_y | input | 1 | Reverse output rows |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rejected | output | 1 | With `done`: configuration was illegal |
| rd_en | output | 1 | Word read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_data | input | 32 | Read word, valid the cycle after `rd_en` |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write word |

## Verification
The assertions rely on two things. First, `rd_data` answers each request exactly one cycle later. Second, reset is held through at least one clock edge before the first `start`. The bench memory model is a single-cycle registered array, and reset is held for several edges before any stimulus, so both conditions hold. The no-write-on-reject property also assumes that writes happen only inside a run. The bench keeps the source and destination regions disjoint and inside the modelled array, and it drives every configuration input from negedge tasks, so nothing changes on a sampling edge.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int PIX_BYTES = 4;
    localparam int LANES     = 4;
    localparam int LANE_W    = 8;
    localparam int SUM_W     = LANE_W + 2;

    typedef logic [LANES-1:0][SUM_W-1:0] lane_sum_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_READ, S_LAST, S_WRITE, S_FIN
    } xfer_state_e;

    localparam logic [1:0] SCALE_NONE = 2'd0;
    localparam logic [1:0] SCALE_H    = 2'd1;
    localparam logic [1:0] SCALE_HV   = 2'd2;

    // Z-order index of a pixel inside an 8x8 block, x in the even bits
    function automatic logic [5:0] zorder6(input logic [2:0] cx, input logic [2:0] cy);
        return {cy[2], cx[2], cy[1], cx[1], cy[0], cx[0]};
    endfunction
endpackage

// File: rtl/xfer_offset.sv
module xfer_offset
    import xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CRD_W  = 11,
    parameter int DIM_W  = 10
) (
    input  logic              tiled,
    input  logic [CRD_W-1:0]  px,
    input  logic [CRD_W-1:0]  py,
    input  logic [DIM_W-1:0]  row_pix,
    output logic [ADDR_W-1:0] byte_off
);
    localparam int PIX_SH = $clog2(PIX_BYTES);

    logic [ADDR_W-1:0] x_w, y_w, row_w, lin_pix, tile_pix, band_pix;

    always_comb begin
        x_w      = ADDR_W'(px);
        y_w      = ADDR_W'(py);
        row_w    = ADDR_W'(row_pix);
        lin_pix  = x_w + y_w * row_w;
        tile_pix = ADDR_W'(zorder6(px[2:0], py[2:0])) + ((x_w >> 3) << 6);
        band_pix = (y_w & ~ADDR_W'(7)) * row_w;
        byte_off = tiled ? ((tile_pix + band_pix) << PIX_SH) : (lin_pix << PIX_SH);
    end
endmodule

// File: rtl/xfer_box_avg.sv
module xfer_box_avg
    import xfer_pkg::*;
(
    input  logic                    clear,
    input  logic                    add,
    input  logic [1:0]              shift,
    input  lane_sum_t               acc_q,
    input  logic [LANES*LANE_W-1:0] word,
    output lane_sum_t               acc_d,
    output logic [LANES*LANE_W-1:0] avg_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign acc_d[g] = clear ? '0 :
                          add   ? acc_q[g] + SUM_W'(word[g*LANE_W +: LANE_W]) :
                                  acc_q[g];
        assign avg_word[g*LANE_W +: LANE_W] = LANE_W'(acc_q[g] >> shift);
    end
endmodule

// File: rtl/xfer_param_check.sv
module xfer_param_check
    import xfer_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DIM_W     = 10,
    parameter int unsigned MEM_BYTES = 32'h0100_0000
) (
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [DIM_W-1:0]  src_w,
    input  logic [DIM_W-1:0]  src_h,
    input  logic [DIM_W-1:0]  dst_w,
    input  logic [DIM_W-1:0]  dst_h,
    input  logic              src_linear,
    input  logic [1:0]        scale_mode,
    output logic              cfg_bad
);
    function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
        return (a[1:0] == 2'b00) && (a < ADDR_W'(MEM_BYTES));
    endfunction

    logic bad_addr, bad_dim, bad_scale;

    always_comb begin
        bad_addr  = !addr_ok(src_base) || !addr_ok(dst_base);
        bad_dim   = (src_w == '0) || (src_h == '0) || (dst_w == '0) || (dst_h == '0);
        bad_scale = (scale_mode > SCALE_HV) || (src_linear && scale_mode != SCALE_NONE);
        cfg_bad   = bad_addr || bad_dim || bad_scale;
    end
endmodule

// File: rtl/disp_xfer_engine.sv
module disp_xfer_engine
    import xfer_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DIM_W     = 10,
    parameter int unsigned MEM_BYTES = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [DIM_W-1:0]  src_w,
    input  logic [DIM_W-1:0]  src_h,
    input  logic [DIM_W-1:0]  dst_w,
    input  logic [DIM_W-1:0]  dst_h,
    input  logic              src_linear,
    input  logic              keep_layout,
    input  logic [1:0]        scale_mode,
    input  logic              flip_y,
    output logic              busy,
    output logic              done,
    output logic              rejected,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data
);
    localparam int CRD_W = DIM_W + 1;

    typedef struct packed {
        xfer_state_e       st;
        logic [ADDR_W-1:0] src_base;
        logic [ADDR_W-1:0] dst_base;
        logic [DIM_W-1:0]  src_w;
        logic [DIM_W-1:0]  src_h;
        logic [DIM_W-1:0]  dst_w;
        logic [DIM_W-1:0]  dst_h;
        logic [DIM_W-1:0]  eff_w;
        logic [DIM_W-1:0]  eff_h;
        logic              src_lin;
        logic              keep;
        logic              flip;
        logic [1:0]        scale;
        logic [DIM_W-1:0]  x;
        logic [DIM_W-1:0]  y;
        logic [1:0]        k;
        lane_sum_t         acc;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic              cfg_bad;
    logic              h_sh, v_sh;
    logic [1:0]        k_last;
    logic [DIM_W-1:0]  w_scaled, h_scaled, out_row;
    logic [CRD_W-1:0]  src_x, src_y;
    logic [ADDR_W-1:0] src_off, dst_off;
    logic              dst_tiled;
    logic              acc_clear, acc_add;
    lane_sum_t         acc_nx;
    logic [31:0]       avg_word;

    xfer_param_check #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .MEM_BYTES(MEM_BYTES)) i_check (
        .src_base  (r_q.src_base),
        .dst_base  (r_q.dst_base),
        .src_w     (r_q.src_w),
        .src_h     (r_q.src_h),
        .dst_w     (r_q.dst_w),
        .dst_h     (r_q.dst_h),
        .src_linear(r_q.src_lin),
        .scale_mode(r_q.scale),
        .cfg_bad   (cfg_bad)
    );

    always_comb begin
        h_sh      = (r_q.scale != SCALE_NONE);
        v_sh      = (r_q.scale == SCALE_HV);
        k_last    = (r_q.scale == SCALE_NONE) ? 2'd0 : (r_q.scale == SCALE_H) ? 2'd1 : 2'd3;
        w_scaled  = r_q.dst_w >> h_sh;
        h_scaled  = r_q.dst_h >> v_sh;
        src_x     = CRD_W'(r_q.x) << h_sh;
        src_y     = CRD_W'(r_q.y) << v_sh;
        out_row   = r_q.flip ? (r_q.eff_h - DIM_W'(1) - r_q.y) : r_q.y;
        dst_tiled = r_q.src_lin ^ r_q.keep;
    end

    xfer_offset #(.ADDR_W(ADDR_W), .CRD_W(CRD_W), .DIM_W(DIM_W)) i_src_off (
        .tiled   (!r_q.src_lin),
        .px      (src_x),
        .py      (src_y),
        .row_pix (r_q.src_w),
        .byte_off(src_off)
    );

    xfer_offset #(.ADDR_W(ADDR_W), .CRD_W(CRD_W), .DIM_W(DIM_W)) i_dst_off (
        .tiled   (dst_tiled),
        .px      (CRD_W'(r_q.x)),
        .py      (CRD_W'(out_row)),
        .row_pix (r_q.eff_w),
        .byte_off(dst_off)
    );

    xfer_box_avg i_avg (
        .clear   (acc_clear),
        .add     (acc_add),
        .shift   (r_q.scale),
        .acc_q   (r_q.acc),
        .word    (rd_data),
        .acc_d   (acc_nx),
        .avg_word(avg_word)
    );

    always_comb begin
        r_d       = r_q;
        rd_en     = 1'b0;
        rd_addr   = '0;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        done      = 1'b0;
        rejected  = 1'b0;
        acc_clear = 1'b0;
        acc_add   = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st       = S_CHECK;
                    r_d.src_base = src_base;
                    r_d.dst_base = dst_base;
                    r_d.src_w    = src_w;
                    r_d.src_h    = src_h;
                    r_d.dst_w    = dst_w;
                    r_d.dst_h    = dst_h;
                    r_d.src_lin  = src_linear;
                    r_d.keep     = keep_layout;
                    r_d.flip     = flip_y;
                    r_d.scale    = scale_mode;
                    r_d.err      = 1'b0;
                end
            end
            S_CHECK: begin
                r_d.x = '0;
                r_d.y = '0;
                r_d.k = '0;
                if (cfg_bad) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_FIN;
                end else begin
                    r_d.eff_w = w_scaled;
                    r_d.eff_h = h_scaled;
                    r_d.st    = (w_scaled == '0 || h_scaled == '0) ? S_FIN : S_READ;
                end
            end
            S_READ: begin
                rd_en     = 1'b1;
                rd_addr   = r_q.src_base + src_off + ADDR_W'({r_q.k, 2'b00});
                acc_clear = (r_q.k == 2'd0);
                acc_add   = (r_q.k != 2'd0);
                r_d.acc   = acc_nx;
                if (r_q.k == k_last) r_d.st = S_LAST;
                else                 r_d.k  = r_q.k + 2'd1;
            end
            S_LAST: begin
                acc_add = 1'b1;
                r_d.acc = acc_nx;
                r_d.st  = S_WRITE;
            end
            S_WRITE: begin
                wr_en   = 1'b1;
                wr_addr = r_q.dst_base + dst_off;
                wr_data = avg_word;
                r_d.k   = '0;
                r_d.st  = S_READ;
                if (r_q.x == r_q.eff_w - DIM_W'(1)) begin
                    r_d.x = '0;
                    if (r_q.y == r_q.eff_h - DIM_W'(1)) r_d.st = S_FIN;
                    else                                r_d.y  = r_q.y + DIM_W'(1);
                end else begin
                    r_d.x = r_q.x + DIM_W'(1);
                end
            end
            S_FIN: begin
                done     = 1'b1;
                rejected = r_q.err;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy = (r_q.st != S_IDLE);
endmodule

// File: rtl/xfer_checker.sv
module xfer_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              rejected,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);
    logic wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wrote_q <= 1'b0;
        else if (start && !busy) wrote_q <= 1'b0;
        else if (wr_en)          wrote_q <= 1'b1;
    end

    AST_REJECT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) rejected |-> done); // R1
    AST_REJECT_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) rejected |-> !wrote_q); // R1
    AST_WR_ALIGNED:       assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (wr_addr[1:0] == 2'b00)); // R5
    AST_RD_WR_EXCL:       assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && wr_en)); // R11
    AST_DONE_PULSE:       assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_WR_IN_RUN:        assert property (@(posedge clk) disable iff (!rst_n) (wr_en || rd_en) |-> busy); // R10
    AST_START_TAKEN:      assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R10
    AST_BUSY_ENDS_DONE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R10
endmodule

bind disp_xfer_engine xfer_checker #(.ADDR_W(ADDR_W)) i_xfer_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rejected(rejected),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/test_disp_xfer_engine.sv
`timescale 1ns/1ps
module test_disp_xfer_engine;
    localparam int AW    = 32;
    localparam int DW    = 10;
    localparam int WORDS = 4096;
    localparam int MEMB  = WORDS * 4;
    localparam logic [AW-1:0] SRC = 32'h0000_0000;
    localparam logic [AW-1:0] DST = 32'h0000_2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = SRC, dst_base = DST;
    logic [DW-1:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
    logic          src_linear = 1'b0, keep_layout = 1'b0, flip_y = 1'b0;
    logic [1:0]    scale_mode = 2'd0;
    logic          busy, done, rejected, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [31:0]   rd_data, wr_data;

    logic [31:0] mem     [WORDS];
    logic [31:0] exp_mem [WORDS];
    logic        fill_go = 1'b0;
    logic [31:0] fill_seed = '0;
    int          wr_cnt;
    int          n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    disp_xfer_engine #(.ADDR_W(AW), .DIM_W(DW), .MEM_BYTES(MEMB)) i_disp_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .src_linear(src_linear), .keep_layout(keep_layout), .scale_mode(scale_mode),
        .flip_y(flip_y), .busy(busy), .done(done), .rejected(rejected),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [31:0] pat(input int i, input logic [31:0] s);
        return (32'(i) * 32'h9E37_79B1) ^ (s * 32'h85EB_CA6B) ^ (32'(i) << 13);
    endfunction

    always @(posedge clk) begin
        if (fill_go) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= pat(i, fill_seed);
            wr_cnt <= 0;
        end else begin
            if (rd_en) rd_data <= mem[rd_addr[13:2]];
            if (wr_en) begin
                mem[wr_addr[13:2]] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Z-order position within an 8x8 block, built bit by bit
    function automatic int zpos(input int x, input int y);
        int r = 0;
        for (int b = 0; b < 3; b++) begin
            r = r | (((x >> b) & 1) << (2 * b)) | (((y >> b) & 1) << (2 * b + 1));
        end
        return r;
    endfunction

    function automatic int lin_off(input int x, input int y, input int w);
        return (y * w + x) * 4;
    endfunction

    function automatic int til_off(input int x, input int y, input int w);
        return 4 * (zpos(x % 8, y % 8) + 64 * (x / 8)) + (y / 8) * 8 * w * 4;
    endfunction

    task automatic fill(input logic [31:0] seed);
        @(negedge clk);
        fill_seed = seed;
        fill_go   = 1'b1;
        @(negedge clk);
        fill_go   = 1'b0;
        for (int i = 0; i < WORDS; i++) exp_mem[i] = pat(i, seed);
    endtask

    task automatic model(input int iw, input int ow, input int oh, input bit lin,
                         input bit keep, input int sc, input bit fl);
        int hs, vs, ew, eh, ns, so, dofs, ix, iy, oy;
        logic [31:0] v;
        hs = (sc != 0) ? 1 : 0;
        vs = (sc == 2) ? 1 : 0;
        ew = ow >> hs;
        eh = oh >> vs;
        ns = 1 << (hs + vs);
        for (int y = 0; y < eh; y++) begin
            for (int x = 0; x < ew; x++) begin
                ix = x << hs;
                iy = y << vs;
                oy = fl ? (eh - 1 - y) : y;
                if (lin) begin
                    so   = lin_off(ix, iy, iw);
                    dofs = keep ? lin_off(x, oy, ew) : til_off(x, oy, ew);
                end else begin
                    so   = til_off(ix, iy, iw);
                    dofs = keep ? til_off(x, oy, ew) : lin_off(x, oy, ew);
                end
                for (int c = 0; c < 4; c++) begin
                    int s = 0;
                    for (int j = 0; j < ns; j++) s += int'(exp_mem[(int'(SRC) + so) / 4 + j][c*8 +: 8]);
                    v[c*8 +: 8] = 8'(s / ns);
                end
                exp_mem[(int'(DST) + dofs) / 4] = v;
            end
        end
    endtask

    task automatic run(input logic [AW-1:0] sb, input logic [AW-1:0] db, input int iw, input int ih,
                       input int ow, input int oh, input bit lin, input bit keep, input int sc,
                       input bit fl, input int hold, output int cyc, output bit rej);
        @(negedge clk);
        src_base = sb; dst_base = db;
        src_w = DW'(iw); src_h = DW'(ih); dst_w = DW'(ow); dst_h = DW'(oh);
        src_linear = lin; keep_layout = keep; scale_mode = 2'(sc); flip_y = fl;
        start = 1'b1;
        cyc = 0;
        rej = 1'b0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc >= hold) start = 1'b0;
            if (done) begin
                rej = rejected;
                break;
            end
        end
        start = 1'b0;
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < WORDS; i++) begin
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, mem[first], exp_mem[first]);
    endtask

    task automatic good_case(input string req, input logic [31:0] seed, input int iw, input int ih,
                             input int ow, input int oh, input bit lin, input bit keep,
                             input int sc, input bit fl, input int hold);
        int cyc, pix, ns;
        bit rej;
        fill(seed);
        model(iw, ow, oh, lin, keep, sc, fl);
        run(SRC, DST, iw, ih, ow, oh, lin, keep, sc, fl, hold, cyc, rej);
        ns  = (sc == 0) ? 1 : (sc == 1) ? 2 : 4;
        pix = (ow >> ((sc != 0) ? 1 : 0)) * (oh >> ((sc == 2) ? 1 : 0));
        cmp_mem(req);
        chk(wr_cnt == pix, {req, " R4 write count"}, 32'(wr_cnt), 32'(pix));
        chk(cyc == 2 + pix * (ns + 2), {req, " R11 run length"}, 32'(cyc), 32'(2 + pix * (ns + 2)));
        chk(!rej, {req, " R1 not rejected"}, 32'(rej), 0);
    endtask

    task automatic bad_case(input string req, input logic [AW-1:0] sb, input logic [AW-1:0] db,
                            input int iw, input int ih, input int ow, input int oh,
                            input bit lin, input int sc);
        int cyc;
        bit rej;
        fill(32'h5151);
        run(sb, db, iw, ih, ow, oh, lin, 1'b0, sc, 1'b0, 1, cyc, rej);
        chk(rej, {req, " rejected flag"}, 32'(rej), 1);
        chk(wr_cnt == 0, {req, " no writes"}, 32'(wr_cnt), 0);
        chk(cyc == 2, {req, " reject timing"}, 32'(cyc), 2);
        cmp_mem({req, " memory untouched"});
    endtask

    task automatic t_reset;
        chk(!busy, "R10 reset busy", 32'(busy), 0);
        chk(!done && !rejected, "R10 reset done/rejected", 32'({done, rejected}), 0);
        chk(!wr_en && !rd_en, "R11 reset strobes", 32'({wr_en, rd_en}), 0);
    endtask

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        // R5 R7 R10: row-major both sides, start held while busy must not restart
        good_case("R5 R7 R10 linear->linear", 32'h11, 8, 4, 8, 4, 1'b1, 1'b1, 0, 1'b0, 3);
        // R6 R7: row-major source, tiled destination
        good_case("R6 R7 linear->tiled", 32'h22, 8, 8, 8, 8, 1'b1, 1'b0, 0, 1'b0, 1);
        // R6 R7: tiled source wider than one block, row-major destination
        good_case("R6 R7 tiled->linear", 32'h33, 16, 8, 16, 8, 1'b0, 1'b0, 0, 1'b0, 1);
        // R2 R4 R9: horizontal halving
        good_case("R2 R4 R9 scale H", 32'h44, 16, 8, 16, 8, 1'b0, 1'b0, 1, 1'b0, 1);
        // R2 R4 R9 R6: both-axis halving, tiled both sides
        good_case("R2 R4 R9 scale HV tiled", 32'h55, 16, 16, 16, 16, 1'b0, 1'b1, 2, 1'b0, 1);
        // R8: flip without scaling
        good_case("R8 flip", 32'h66, 8, 8, 8, 8, 1'b0, 1'b0, 0, 1'b1, 1);
        // R8: flip applied after scaling
        good_case("R8 flip scaled", 32'h77, 16, 16, 16, 16, 1'b0, 1'b1, 2, 1'b1, 1);
        // R1 rejects
        bad_case("R1 zero src height", SRC, DST, 8, 0, 8, 8, 1'b1, 0);
        bad_case("R1 zero dst width", SRC, DST, 8, 8, 0, 8, 1'b1, 0);
        bad_case("R1 misaligned src", SRC + 2, DST, 8, 8, 8, 8, 1'b1, 0);
        bad_case("R1 dst beyond memory", SRC, 32'(MEMB), 8, 8, 8, 8, 1'b1, 0);
        bad_case("R2 scale code 3", SRC, DST, 16, 16, 16, 16, 1'b0, 3);
        bad_case("R3 scale with linear source", SRC, DST, 16, 8, 16, 8, 1'b1, 1);
        // engine still usable after rejects
        good_case("R10 after reject", 32'h88, 8, 8, 8, 8, 1'b1, 1'b1, 0, 1'b0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule